// File: doc/BRIEF.md
# Spread-Spectrum Switching Clock Stepper

This block dithers the switching rate of a converter around a 3 MHz nominal to spread electromagnetic emission over a band rather than a single tone. It divides a reference clock by an integer and emits a one-cycle switching enable per period. While dithering is active it walks through eight frequency offsets, four above nominal and four below, in 2.5 % steps, so the outermost steps sit at ±10 %. One offset is held for a fixed dwell of `DWELL_TICKS` pulses of an external tick source. With the default 1 µs tick and 170 pulses, the dwell is 170 µs.

The walk is a triangle through the offset table ordered from slowest to fastest. Each move changes the offset by one table position, and the walk reverses at either end. The dither enable is sampled only at dwell boundaries. When dithering is off, the divider stays at `NOM_DIV`. With a 120 MHz reference and the default `NOM_DIV` of 40, that divider value gives exactly 3 MHz. A new divider value is loaded only when the running switching period ends, so no period is ever cut short.

Top module: `ssc_stepper`

## Requirements
- R1: During and right after reset, `step_o` is 0, `div_o` equals `NOM_DIV`, `sw_en_o` is low, and the dither is inactive.
- R2: A dwell boundary occurs on every `DWELL_TICKS`-th cycle in which `tick_i` is high. Cycles with `tick_i` low do not advance the dwell count. With `tick_i` held high, an active step therefore lasts exactly `DWELL_TICKS` cycles.
- R3: `en_i` is sampled only at a dwell boundary, and `step_o` changes only in the cycle after a boundary. At a boundary with `en_i` high, an inactive stepper becomes active with step +1 and moving upward. At a boundary with `en_i` low, the stepper becomes inactive.
- R4: While active, the step index follows the order -4,-3,-2,-1,+1,+2,+3,+4 upward and the reverse order downward. After +4 it moves to +3 and turns downward. After -4 it moves to -3 and turns upward.
- R5: `step_o` is a signed two's complement code. While active it is never 0 and its magnitude is at most `LEVELS`.
- R6: `div_o` = round(`NOM_DIV`·`SPAN_DEN`/(`SPAN_DEN`+step)). With the defaults (40, 40), steps -4..+4 give 44,43,42,41,40,39,38,37,36, so ±4 land at ±10 % frequency.
- R7: While inactive, `step_o` is 0 and `div_o` equals `NOM_DIV`.
- R8: `sw_en_o` is a one-cycle pulse. The gap between consecutive pulses equals the `div_o` value present in the cycle of the earlier pulse, so a divider change applies only from the next whole period.
- R9: Two consecutive active step values are always one table position apart in the order of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Dither request, sampled at dwell boundaries |
| tick_i | input | 1 | Dwell time-base pulse |
| step_o | output | STEP_W (4) | Signed frequency step index, 0 at nominal |
| div_o | output | DIV_W (6) | Divider setting for the current step |
| sw_en_o | output | 1 | One-cycle switching clock enable |

## Verification
A dwell boundary can fall in the same cycle as the end of a switching period. In that cycle the period must reload with the old divider, and the new step's divider must apply only from the following period. A second collision is an `en_i` change in the same cycle as a boundary, which must be honoured, while a change one cycle earlier or later must not be. Both collisions are provoked by running the tick source continuously and then gapped by a pseudo-random pattern, with `en_i` toggled at several offsets, including short pulses. A behavioural model of dwell count, step walk and period countdown is compared with all three outputs in every cycle.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  // rounded nom*den/(den+k)
  function automatic int unsigned div_for_step(int unsigned nom, int unsigned den, int k);
    int unsigned d;
    d = int'(den) + k;
    return (2 * nom * den + d) / (2 * d);
  endfunction

  // table position -> signed step, skipping zero
  function automatic int step_of_pos(int pos, int levels);
    return (pos < levels) ? pos - levels : pos - levels + 1;
  endfunction

endpackage

// File: rtl/ssc_dwell_timer.sv
module ssc_dwell_timer #(
  parameter int unsigned DWELL_TICKS = 170,
  localparam int unsigned CNT_W = (DWELL_TICKS > 1) ? $clog2(DWELL_TICKS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic bnd_o
);

  logic [CNT_W-1:0] cnt_q;

  assign bnd_o = tick_i && (cnt_q == CNT_W'(DWELL_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= bnd_o ? '0 : cnt_q + CNT_W'(1);
  end

  // R2: count advances only on ticks
  a_r2_count_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/ssc_step_seq.sv
module ssc_step_seq
  import ssc_pkg::*;
#(
  parameter int unsigned NOM_DIV  = 40,
  parameter int unsigned SPAN_DEN = 40,
  parameter int unsigned LEVELS   = 4,
  parameter int unsigned STEP_W   = 4,
  parameter int unsigned DIV_W    = 6,
  localparam int unsigned STEPS   = 2 * LEVELS,
  localparam int unsigned POS_W   = $clog2(STEPS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     bnd_i,
  output logic signed [STEP_W-1:0] step_o,
  output logic [DIV_W-1:0]         div_o
);

  logic [DIV_W-1:0]         div_tab  [STEPS];
  logic signed [STEP_W-1:0] code_tab [STEPS];

  for (genvar g = 0; g < STEPS; g++) begin : g_tab
    assign div_tab[g]  = DIV_W'(div_for_step(NOM_DIV, SPAN_DEN, step_of_pos(g, LEVELS)));
    assign code_tab[g] = STEP_W'(step_of_pos(g, LEVELS));
  end

  logic             act_q, up_q;
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      up_q  <= 1'b1;
      pos_q <= POS_W'(LEVELS);
    end else if (bnd_i) begin
      if (!en_i) begin
        act_q <= 1'b0;
      end else if (!act_q) begin
        act_q <= 1'b1;
        up_q  <= 1'b1;
        pos_q <= POS_W'(LEVELS);
      end else if (up_q) begin
        if (pos_q == POS_W'(STEPS - 1)) begin
          up_q  <= 1'b0;
          pos_q <= pos_q - POS_W'(1);
        end else begin
          pos_q <= pos_q + POS_W'(1);
        end
      end else begin
        if (pos_q == '0) begin
          up_q  <= 1'b1;
          pos_q <= pos_q + POS_W'(1);
        end else begin
          pos_q <= pos_q - POS_W'(1);
        end
      end
    end
  end

  assign step_o = act_q ? code_tab[pos_q] : '0;
  assign div_o  = act_q ? div_tab[pos_q]  : DIV_W'(NOM_DIV);

  logic [POS_W:0] pos_ext;
  assign pos_ext = {1'b0, pos_q};

  // R5: active step is never nominal
  a_r5_active_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (step_o != '0));

  // R3: step only moves after a boundary
  a_r3_boundary_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_i |=> $stable(step_o));

  // R9: one table position per move
  a_r9_adjacent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && $past(act_q) && (pos_ext != $past(pos_ext))) |->
      ((pos_ext == $past(pos_ext) + (POS_W+1)'(1)) || (pos_ext + (POS_W+1)'(1) == $past(pos_ext))));

  // R7: idle sits at nominal
  a_r7_idle_nominal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> (div_o == DIV_W'(NOM_DIV) && step_o == '0));

endmodule

// File: rtl/ssc_clk_div.sv
module ssc_clk_div #(
  parameter int unsigned NOM_DIV = 40,
  parameter int unsigned DIV_MIN = 36,
  parameter int unsigned DIV_MAX = 44,
  parameter int unsigned DIV_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             sw_en_o
);

  logic [DIV_W-1:0] dcnt_q;

  assign sw_en_o = (dcnt_q == '0);

  // reload only at period end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dcnt_q <= DIV_W'(NOM_DIV - 1);
    else if (sw_en_o) dcnt_q <= div_i - DIV_W'(1);
    else              dcnt_q <= dcnt_q - DIV_W'(1);
  end

  // R8: enable is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_en_o |=> !sw_en_o);

  // R6: divider input stays within the dither span
  a_r6_div_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i >= DIV_W'(DIV_MIN)) && (div_i <= DIV_W'(DIV_MAX)));

endmodule

// File: rtl/ssc_stepper.sv
module ssc_stepper
  import ssc_pkg::*;
#(
  parameter int unsigned NOM_DIV     = 40,
  parameter int unsigned SPAN_DEN    = 40,
  parameter int unsigned LEVELS      = 4,
  parameter int unsigned DWELL_TICKS = 170,
  localparam int unsigned STEP_W  = $clog2(LEVELS + 1) + 1,
  localparam int unsigned DIV_MAX = div_for_step(NOM_DIV, SPAN_DEN, -int'(LEVELS)),
  localparam int unsigned DIV_MIN = div_for_step(NOM_DIV, SPAN_DEN, int'(LEVELS)),
  localparam int unsigned DIV_W   = $clog2(DIV_MAX + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     tick_i,
  output logic signed [STEP_W-1:0] step_o,
  output logic [DIV_W-1:0]         div_o,
  output logic                     sw_en_o
);

  logic bnd;

  ssc_dwell_timer #(.DWELL_TICKS(DWELL_TICKS)) u_dwell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .bnd_o  (bnd)
  );

  ssc_step_seq #(
    .NOM_DIV (NOM_DIV),
    .SPAN_DEN(SPAN_DEN),
    .LEVELS  (LEVELS),
    .STEP_W  (STEP_W),
    .DIV_W   (DIV_W)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .bnd_i  (bnd),
    .step_o (step_o),
    .div_o  (div_o)
  );

  ssc_clk_div #(
    .NOM_DIV(NOM_DIV),
    .DIV_MIN(DIV_MIN),
    .DIV_MAX(DIV_MAX),
    .DIV_W  (DIV_W)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_o),
    .sw_en_o(sw_en_o)
  );

endmodule

// File: tb/sim_ssc_stepper.sv
`timescale 1ns/1ps
module sim_ssc_stepper;

  localparam int NOM = 40;
  localparam int DEN = 40;
  localparam int LV  = 4;
  localparam int DW  = 170;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic tick = 1'b0;
  logic signed [3:0] step_o;
  logic [5:0] div_o;
  logic sw_en;

  always #2 clk = ~clk;

  ssc_stepper u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick),
    .step_o(step_o), .div_o(div_o), .sw_en_o(sw_en)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_div(int k);
    if (k == 0) return NOM;
    return ((NOM * DEN * 2) / (DEN + k) + 1) / 2;
  endfunction

  // ---- behavioural reference ----
  int m_cnt, m_k, m_dc;
  bit m_act, m_up, m_bnd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_k = 0; m_act = 0; m_up = 1; m_dc = NOM - 1; m_bnd = 0;
    end else begin
      m_bnd = tick && (m_cnt == DW - 1);
      if (tick) m_cnt = m_bnd ? 0 : m_cnt + 1;
      if (m_dc == 0) m_dc = exp_div(m_k) - 1;
      else m_dc = m_dc - 1;
      if (m_bnd) begin
        if (!en) begin m_act = 0; m_k = 0; end
        else if (!m_act) begin m_act = 1; m_k = 1; m_up = 1; end
        else if (m_up) begin
          if (m_k == LV) begin m_up = 0; m_k = LV - 1; end
          else m_k = (m_k == -1) ? 1 : m_k + 1;
        end else begin
          if (m_k == -LV) begin m_up = 1; m_k = -LV + 1; end
          else m_k = (m_k == 1) ? -1 : m_k - 1;
        end
      end
    end
  end

  function automatic int pos_of(int k);
    return (k < 0) ? k + LV : k + LV - 1;
  endfunction

  // ---- per-cycle compare ----
  int prev_k = 0;
  bit prev_act = 0;
  bit seen_hi = 0, seen_lo = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(step_o) == m_k, "R4 step order", int'(step_o), m_k);
      chk(int'(div_o) == exp_div(m_k), "R6 divider", int'(div_o), exp_div(m_k));
      chk(sw_en == (m_dc == 0), "R8 switch enable", int'(sw_en), int'(m_dc == 0));
      if (int'(step_o) != prev_k)
        chk(m_bnd, "R3 change off boundary", int'(step_o), prev_k);
      if (m_act)
        chk(step_o != 0 && step_o <= LV && step_o >= -LV, "R5 active range", int'(step_o), m_k);
      if (m_act && prev_act && int'(step_o) != prev_k) begin
        int d;
        d = pos_of(int'(step_o)) - pos_of(prev_k);
        chk(d == 1 || d == -1, "R9 adjacency", d, 1);
      end
      if (step_o == 4 && !seen_hi) begin
        seen_hi = 1; chk(div_o == 6'd36, "R6 top step", int'(div_o), 36);
      end
      if (step_o == -4 && !seen_lo) begin
        seen_lo = 1; chk(div_o == 6'd44, "R6 bottom step", int'(div_o), 44);
      end
      prev_k = int'(step_o);
      prev_act = m_act;
    end
  end

  // ---- stimulus ----
  initial begin : stim
    logic [7:0] lfsr;
    lfsr = 8'h5a;
    repeat (3) @(negedge clk);
    chk(step_o == 0 && div_o == 6'd40 && !sw_en, "R1 in reset", int'(div_o), NOM);
    rst_n = 1'b1;
    @(negedge clk);
    chk(step_o == 0 && div_o == 6'd40 && !sw_en, "R1 after reset", int'(div_o), NOM);
    tick = 1'b1;
    repeat (400) @(negedge clk);
    chk(step_o == 0 && div_o == 6'd40, "R7 idle nominal", int'(div_o), NOM);
    repeat (37) @(negedge clk);
    en = 1'b1;
    // R2: measure dwell length with continuous ticks
    begin
      int n;
      while (step_o != 1) @(negedge clk);
      n = 0;
      while (step_o == 1) begin @(negedge clk); n++; end
      chk(n == DW, "R2 dwell length", n, DW);
    end
    repeat (5200) @(negedge clk);
    chk(seen_hi && seen_lo, "R4 both ends reached", int'(seen_hi) + int'(seen_lo), 2);
    en = 1'b0;
    repeat (400) @(negedge clk);
    chk(step_o == 0 && div_o == 6'd40, "R7 disabled nominal", int'(div_o), NOM);
    // short enable pulses at varied offsets
    for (int i = 0; i < 12; i++) begin
      repeat (23 + 11 * i) @(negedge clk);
      en = 1'b1;
      repeat (1 + (i % 3)) @(negedge clk);
      en = 1'b0;
    end
    // gapped ticks
    en = 1'b1;
    for (int i = 0; i < 9000; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tick = lfsr[0] | lfsr[1];
      if (i == 6000) en = 1'b0;
      @(negedge clk);
    end
    tick = 1'b1;
    repeat (400) @(negedge clk);
    chk(step_o == 0 && div_o == 6'd40, "R7 final idle", int'(div_o), NOM);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule